// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block decides, at each instruction boundary of a small processor, whether an interrupt should be taken and which device it belongs to. Every device has a configurable priority level. When the processor signals a boundary, the block finds the highest level among the devices that are requesting. It takes an interrupt only if that level is strictly above the current processor priority. It then reports the winning device index and a vector derived from it, raises the current priority to the winner's level, and pushes the interrupted priority onto an internal stack.

When the handler finishes, the processor pulses the return strobe. The block pops the saved priority and reinstates it. Because only a strictly higher level can preempt, handlers nest by level and a handler is never re-entered. Devices that share a level are ranked by a fixed chain in which the lower device index goes first. A device configured at level 0 matches normal program execution and therefore can never interrupt.

Top module: `pic_preempt_top`

## Requirements
- R1: After reset, take and stack_err are 0, cur_pri is 0, and take_dev and take_vec are 0.
- R2: Requests are sampled only in cycles where boundary is 1. Without boundary, no take occurs and cur_pri keeps its value.
- R3: If boundary is 1 and the highest requesting level is greater than the current priority, take is 1 for one cycle after that clock edge, and cur_pri then equals the winner's level.
- R4: A request whose level is equal to or below cur_pri causes no take and leaves cur_pri unchanged.
- R5: Among requesters on different levels, the device with the highest level wins, whatever its index.
- R6: Among requesters on the same highest level, the lowest device index wins.
- R7: With take, take_dev is the winner's index and take_vec equals VEC_BASE plus that index (VEC_BASE defaults to 0x20).
- R8: A device configured at level 0 never causes a take.
- R9: ret with a non-empty stack restores the priority that was current when the most recent outstanding interrupt was taken. Nested returns unwind in LIFO order.
- R10: ret with an empty stack leaves cur_pri unchanged and pulses stack_err for one cycle.
- R11: When ret and boundary are 1 in the same cycle, the return is applied first, and arbitration compares against the restored priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_DEV | Level-sensitive request per device |
| dev_level | input | NUM_DEV*LVL_W | Priority level per device; device i in bits [i*LVL_W +: LVL_W] |
| boundary | input | 1 | Instruction boundary strobe; arbitrate this cycle |
| ret | input | 1 | Handler return strobe |
| take | output | 1 | One-cycle pulse: interrupt taken |
| take_dev | output | DEV_W | Index of the winning device |
| take_vec | output | VEC_W | VEC_BASE plus winning index |
| cur_pri | output | LVL_W | Current processor priority |
| stack_err | output | 1 | One-cycle pulse: return with empty stack |

## Verification
The arbitration is driven with three level maps: level equal to index, all devices on one shared level, and level inverse to index. Requests are applied as single bits, sparse sets and all-ones. This separates "highest level wins" from "lowest index wins" and shows that a level-0 requester is ignored. Directed sequences build nested handlers to show that equal and lower levels are refused, that returns unwind in LIFO order and that an empty-stack return is flagged. A final case pulses return and boundary in the same cycle, with a request that can only win against the restored priority.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DEF_NUM_DEV = 8;
  localparam int DEF_LVL_W   = 3;
  localparam int DEF_VEC_W   = 8;

  // Operation applied to the priority stack in one cycle
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3   // pop then push in the same cycle
  } stk_op_e;
endpackage

// File: rtl/pic_chain_arb.sv
module pic_chain_arb #(
  parameter int NUM_DEV = pic_pkg::DEF_NUM_DEV,
  parameter int LVL_W   = pic_pkg::DEF_LVL_W,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] levels,
  output logic [LVL_W-1:0]         win_lvl,
  output logic [DEV_W-1:0]         win_idx
);
  logic [LVL_W-1:0] lvl_a [NUM_DEV];

  // Requests on level 0 are masked to level 0 and so never beat anything
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_unpack
    assign lvl_a[g] = req[g] ? levels[g*LVL_W +: LVL_W] : '0;
  end

  // Strict compare keeps the earlier (lower index) device on ties: chain order
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (lvl_a[i] > win_lvl) begin
        win_lvl = lvl_a[i];
        win_idx = DEV_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_pri_stack.sv
module pic_pri_stack #(
  parameter int LVL_W  = pic_pkg::DEF_LVL_W,
  localparam int DEPTH = 1 << LVL_W,
  localparam int SP_W  = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  pic_pkg::stk_op_e op,
  input  logic [LVL_W-1:0] push_val,
  output logic [LVL_W-1:0] top_val,
  output logic             empty
);
  import pic_pkg::*;

  logic [LVL_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  sp_m1;
  logic [LVL_W-1:0] wr_addr;
  logic             wr_en;

  assign sp_m1   = sp - SP_W'(1);
  assign empty   = (sp == '0);
  assign top_val = mem[sp_m1[LVL_W-1:0]];
  assign wr_en   = (op == STK_PUSH) || (op == STK_SWAP);
  assign wr_addr = (op == STK_SWAP) ? sp_m1[LVL_W-1:0] : sp[LVL_W-1:0];

  // Storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else begin
      case (op)
        STK_PUSH: sp <= sp + SP_W'(1);
        STK_POP:  sp <= sp_m1;
        default:  sp <= sp;
      endcase
    end
  end
endmodule

// File: rtl/pic_preempt_top.sv
module pic_preempt_top #(
  parameter int NUM_DEV  = pic_pkg::DEF_NUM_DEV,
  parameter int LVL_W    = pic_pkg::DEF_LVL_W,
  parameter int VEC_W    = pic_pkg::DEF_VEC_W,
  parameter int VEC_BASE = 32,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_DEV-1:0]       irq_req,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level,
  input  logic                     boundary,
  input  logic                     ret,
  output logic                     take,
  output logic [DEV_W-1:0]         take_dev,
  output logic [VEC_W-1:0]         take_vec,
  output logic [LVL_W-1:0]         cur_pri,
  output logic                     stack_err
);
  import pic_pkg::*;

  logic [LVL_W-1:0] arb_lvl;
  logic [DEV_W-1:0] arb_idx;
  logic [LVL_W-1:0] stk_top;
  logic             stk_empty;
  logic             pop_ok;
  logic             ret_bad;
  logic [LVL_W-1:0] pri_eff;
  logic             take_now;
  stk_op_e          stk_op;

  pic_chain_arb #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_arb (
    .req     (irq_req),
    .levels  (dev_level),
    .win_lvl (arb_lvl),
    .win_idx (arb_idx)
  );

  pic_pri_stack #(.LVL_W(LVL_W)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .op       (stk_op),
    .push_val (pri_eff),
    .top_val  (stk_top),
    .empty    (stk_empty)
  );

  // Return is resolved first; arbitration sees the restored priority
  assign pop_ok   = ret & ~stk_empty;
  assign ret_bad  = ret & stk_empty;
  assign pri_eff  = pop_ok ? stk_top : cur_pri;
  assign take_now = boundary && (arb_lvl > pri_eff);

  always_comb begin
    case ({take_now, pop_ok})
      2'b10:   stk_op = STK_PUSH;
      2'b01:   stk_op = STK_POP;
      2'b11:   stk_op = STK_SWAP;
      default: stk_op = STK_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      take_dev  <= '0;
      take_vec  <= '0;
      cur_pri   <= '0;
      stack_err <= 1'b0;
    end else begin
      take      <= take_now;
      stack_err <= ret_bad;
      cur_pri   <= take_now ? arb_lvl : pri_eff;
      if (take_now) begin
        take_dev <= arb_idx;
        take_vec <= VEC_W'(VEC_BASE) + VEC_W'(arb_idx);
      end
    end
  end
endmodule

// File: rtl/pic_preempt_chk.sv
module pic_preempt_chk #(
  parameter int NUM_DEV  = 8,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int DEV_W    = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_DEV-1:0]       irq_req,
  input logic [NUM_DEV*LVL_W-1:0] dev_level,
  input logic                     boundary,
  input logic                     ret,
  input logic                     take,
  input logic [DEV_W-1:0]         take_dev,
  input logic [VEC_W-1:0]         take_vec,
  input logic [LVL_W-1:0]         cur_pri,
  input logic                     stack_err
);
  logic [NUM_DEV-1:0]       req_q;
  logic [NUM_DEV*LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    req_q <= irq_req;
    lvl_q <= dev_level;
  end

  p_take_needs_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(boundary));

  p_take_winner_requested_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> req_q[take_dev]);

  p_take_sets_level_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> cur_pri == lvl_q[take_dev*LVL_W +: LVL_W]);

  p_strict_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (take && !$past(ret)) |-> cur_pri > $past(cur_pri));

  p_vector_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> take_vec == VEC_W'(VEC_BASE) + VEC_W'(take_dev));

  p_level0_silent_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> cur_pri != '0);

  p_empty_return_r10: assert property (@(posedge clk) disable iff (rst)
    stack_err |-> ($past(ret) && $past(cur_pri) == '0));
endmodule

bind pic_preempt_top pic_preempt_chk #(
  .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .DEV_W(DEV_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .dev_level(dev_level),
  .boundary(boundary), .ret(ret), .take(take), .take_dev(take_dev),
  .take_vec(take_vec), .cur_pri(cur_pri), .stack_err(stack_err)
);

// File: tb/pic_preempt_top_tb_top.sv
`timescale 1ns/1ps
module pic_preempt_top_tb_top;
  localparam int NDEV = 8;
  localparam int LW   = 3;
  localparam int VW   = 8;
  localparam int VB   = 32;

  localparam logic [23:0] L_IDX = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
  localparam logic [23:0] L_ONE = {8{3'd3}};
  localparam logic [23:0] L_REV = {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7};

  // {levels, requests, expect take, expect device, expect priority}
  localparam int NV = 8;
  localparam logic [38:0] VECS [NV] = '{
    {L_IDX, 8'b1000_0000, 1'b1, 3'd7, 3'd7},
    {L_IDX, 8'b0001_0110, 1'b1, 3'd4, 3'd4},
    {L_IDX, 8'b0000_0001, 1'b0, 3'd0, 3'd0},
    {L_ONE, 8'b0110_0000, 1'b1, 3'd5, 3'd3},
    {L_ONE, 8'b1000_0000, 1'b1, 3'd7, 3'd3},
    {L_REV, 8'b1111_1111, 1'b1, 3'd0, 3'd7},
    {L_REV, 8'b1000_0000, 1'b0, 3'd0, 3'd0},
    {L_IDX, 8'b0000_0000, 1'b0, 3'd0, 3'd0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NDEV-1:0] irq_req = '0;
  logic [23:0]     dev_level = '0;
  logic            boundary = 1'b0;
  logic            ret = 1'b0;
  logic            take;
  logic [2:0]      take_dev;
  logic [VW-1:0]   take_vec;
  logic [LW-1:0]   cur_pri;
  logic            stack_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pic_preempt_top #(.NUM_DEV(NDEV), .LVL_W(LW), .VEC_W(VW), .VEC_BASE(VB)) dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .dev_level(dev_level),
    .boundary(boundary), .ret(ret), .take(take), .take_dev(take_dev),
    .take_vec(take_vec), .cur_pri(cur_pri), .stack_err(stack_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; boundary = 1'b0; ret = 1'b0; irq_req = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One cycle of strobes; outputs checked at the following falling edge
  task automatic pulse(input bit b, input bit r);
    boundary = b; ret = r;
    @(negedge clk);
    boundary = 1'b0; ret = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(take == 1'b0, "R1 take", int'(take), 0);
    chk(cur_pri == 3'd0, "R1 cur_pri", int'(cur_pri), 0);
    chk(stack_err == 1'b0, "R1 stack_err", int'(stack_err), 0);
    chk(take_dev == 3'd0 && take_vec == 8'd0, "R1 dev/vec", int'(take_vec), 0);

    // Table: R3 R5 R6 R7 R8 from a clean state each time
    for (int k = 0; k < NV; k++) begin
      do_reset();
      dev_level = VECS[k][38:15];
      irq_req   = VECS[k][14:7];
      pulse(1'b1, 1'b0);
      chk(take == VECS[k][6], $sformatf("R3/R8 take v%0d", k), int'(take), int'(VECS[k][6]));
      chk(cur_pri == VECS[k][2:0], $sformatf("R3 cur_pri v%0d", k), int'(cur_pri), int'(VECS[k][2:0]));
      if (VECS[k][6]) begin
        chk(take_dev == VECS[k][5:3], $sformatf("R5/R6 dev v%0d", k), int'(take_dev), int'(VECS[k][5:3]));
        chk(take_vec == VW'(VB) + VW'(VECS[k][5:3]), $sformatf("R7 vec v%0d", k),
            int'(take_vec), VB + int'(VECS[k][5:3]));
      end
      @(negedge clk);
      chk(take == 1'b0, $sformatf("R3 single pulse v%0d", k), int'(take), 0);
    end

    // R2: requests without boundary
    do_reset();
    dev_level = L_IDX; irq_req = 8'h80;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(take == 1'b0, "R2 no boundary take", int'(take), 0);
    end
    chk(cur_pri == 3'd0, "R2 cur_pri", int'(cur_pri), 0);

    // R4, R9, R10: nesting and unwinding
    do_reset();
    dev_level = L_IDX; irq_req = 8'b0000_1000;
    pulse(1'b1, 1'b0);
    chk(take && cur_pri == 3'd3, "R3 enter level3", int'(cur_pri), 3);
    irq_req = 8'b0000_1100;
    pulse(1'b1, 1'b0);
    chk(take == 1'b0, "R4 equal/lower refused", int'(take), 0);
    chk(cur_pri == 3'd3, "R4 cur_pri kept", int'(cur_pri), 3);
    irq_req = 8'b0100_1100;
    pulse(1'b1, 1'b0);
    chk(take && take_dev == 3'd6, "R3 preempt by 6", int'(take_dev), 6);
    chk(cur_pri == 3'd6, "R3 cur_pri 6", int'(cur_pri), 6);
    irq_req = '0;
    pulse(1'b0, 1'b1);
    chk(cur_pri == 3'd3, "R9 first return", int'(cur_pri), 3);
    chk(stack_err == 1'b0, "R9 no error", int'(stack_err), 0);
    pulse(1'b0, 1'b1);
    chk(cur_pri == 3'd0, "R9 second return", int'(cur_pri), 0);
    pulse(1'b0, 1'b1);
    chk(stack_err == 1'b1, "R10 empty return flag", int'(stack_err), 1);
    chk(cur_pri == 3'd0, "R10 cur_pri kept", int'(cur_pri), 0);
    @(negedge clk);
    chk(stack_err == 1'b0, "R10 flag one cycle", int'(stack_err), 0);

    // R11: return and boundary together
    do_reset();
    dev_level = L_IDX; irq_req = 8'b0010_0000;
    pulse(1'b1, 1'b0);
    chk(cur_pri == 3'd5, "R11 setup level5", int'(cur_pri), 5);
    irq_req = 8'b0001_0000;
    pulse(1'b1, 1'b1);
    chk(take == 1'b1 && take_dev == 3'd4, "R11 take after restore", int'(take_dev), 4);
    chk(cur_pri == 3'd4, "R11 cur_pri 4", int'(cur_pri), 4);
    irq_req = '0;
    pulse(1'b0, 1'b1);
    chk(cur_pri == 3'd0, "R11 unwind to 0", int'(cur_pri), 0);
    pulse(1'b0, 1'b1);
    chk(stack_err == 1'b1, "R11 stack depth after swap", int'(stack_err), 1);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule